// File: doc/BRIEF.md
# Key-based instruction fetch protection checker

This block gives the final execute decision for an instruction fetch once the page translation is known. It holds a 64-bit fetch-key mask register that software writes and reads back. The register is split into 32 two-bit fields, and each field belongs to one protection key value. For each fetch request the block takes three inputs: the second doubleword of the page table entry, the execute permission that the ordinary page-protection check produced, and an enable that turns the key check on.

The block builds a 5-bit protection key from two separate fields of the page table entry. It looks up that key's mask field and combines the result with the basic execute permission. One cycle after the request it returns a registered allow/deny result. With that result comes a 32-bit status word that names every cause of a denial. When both the key check and the basic check refuse a fetch, both cause bits are set.

Top module: `ifp_fetch_guard`

## Requirements
- R1: While `rst_ni` is low, and afterwards until the first write, the mask register reads back as zero (every key allowed) and `rsp_valid_o` is low.
- R2: The protection key is {`pte_dw1_i`[61:60], `pte_dw1_i`[11:9]}, with bit 61 as the key's most significant bit. No other bit of `pte_dw1_i` affects the result.
- R3: The mask field for key k is register bits [2*(31-k)+1 : 2*(31-k)]. Key 0 therefore uses bits 63:62 and key 31 uses bits 1:0. When `key_chk_en_i` is high and bit 2*(31-k) is 1, the key check denies the fetch.
- R4: The upper bit of each mask field, bit 2*(31-k)+1, has no effect on the result.
- R5: When `key_chk_en_i` is low, the key check never denies and status bit 21 is never set.
- R6: When the key check denies, `status_o` has bit 21 set (0x00200000).
- R7: When `base_exec_i` is low, the fetch is denied and `status_o` has bit 27 set (0x08000000). If the key check also denies, both bits are set (0x08200000).
- R8: `exec_ok_o` equals `base_exec_i` AND NOT (key denial). When the fetch is allowed, `status_o` is zero.
- R9: A request pulse on `req_valid_i` produces `rsp_valid_o`, `exec_ok_o` and `status_o` exactly one clock later. `rsp_valid_o` is high only in that cycle, and back-to-back requests each get their own result.
- R10: A mask write with `mask_wr_i` applies to requests issued in later cycles. A request in the same cycle as the write still uses the old value. `mask_rdata_o` shows the written value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask_wr_i | input | 1 | Write strobe for the fetch-key mask register |
| mask_wdata_i | input | 64 | Value to write into the mask register |
| mask_rdata_o | output | 64 | Current contents of the mask register |
| req_valid_i | input | 1 | Single-cycle fetch check request |
| pte_dw1_i | input | 64 | Second doubleword of the page table entry |
| base_exec_i | input | 1 | Execute permission from the basic page-protection check |
| key_chk_en_i | input | 1 | Enables the key-based check |
| rsp_valid_o | output | 1 | Result valid, one cycle after the request |
| exec_ok_o | output | 1 | Fetch allowed |
| status_o | output | 32 | Fault causes: bit 27 for basic protection, bit 21 for the key check |

## Verification
The assertions assume that `req_valid_i` is a one-cycle pulse per fetch and that the request inputs are valid whenever it is high. They do not depend on mask writes and requests being kept apart, since a write in the same cycle as a request is defined behaviour. The scoreboard drives every input on the falling clock edge. It models the mask register in the bench, updating that model only after the edge that performs the write, so a request issued alongside a write is scored against the old mask. The stimulus covers all four combinations of the two checks, the key values at both ends of the register, a noisy page table entry, and requests on consecutive cycles.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
  localparam int DW        = 64;
  localparam int KEY_W     = 5;
  localparam int NUM_KEYS  = 1 << KEY_W;
  localparam int FLD_W     = DW / NUM_KEYS;
  localparam int STAT_W    = 32;
  localparam int KEY_HI_MSB = 61;
  localparam int KEY_HI_LSB = 60;
  localparam int KEY_LO_MSB = 11;
  localparam int KEY_LO_LSB = 9;
  localparam logic [STAT_W-1:0] STAT_KEY  = 32'h0020_0000;
  localparam logic [STAT_W-1:0] STAT_BASE = 32'h0800_0000;

  typedef logic [KEY_W-1:0] key_t;
  typedef logic [FLD_W-1:0] fld_t;

  typedef struct packed {
    logic              exec_ok;
    logic [STAT_W-1:0] status;
  } verdict_t;
endpackage

// File: rtl/ifp_key_extract.sv
module ifp_key_extract
  import ifp_pkg::*;
(
  input  logic [DW-1:0] pte_dw1_i,
  output key_t          key_o
);
  assign key_o = {pte_dw1_i[KEY_HI_MSB:KEY_HI_LSB], pte_dw1_i[KEY_LO_MSB:KEY_LO_LSB]};
endmodule

// File: rtl/ifp_mask_reg.sv
module ifp_mask_reg
  import ifp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  key_t          key_i,
  output logic [DW-1:0] q_o,
  output fld_t          fld_o
);
  logic [DW-1:0] mask_q;
  fld_t          fld [NUM_KEYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i;
  end

  // key 0 sits at the most significant end
  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_fld
    assign fld[g] = mask_q[FLD_W*(NUM_KEYS-1-g) +: FLD_W];
  end

  assign fld_o = fld[key_i];
  assign q_o   = mask_q;
endmodule

// File: rtl/ifp_decide.sv
module ifp_decide
  import ifp_pkg::*;
(
  input  logic     base_exec_i,
  input  logic     key_chk_en_i,
  input  fld_t     fld_i,
  output verdict_t verdict_o
);
  logic key_deny;

  // only the low mask bit governs fetches
  assign key_deny = key_chk_en_i & fld_i[0];

  always_comb begin
    verdict_o.exec_ok = base_exec_i & ~key_deny;
    verdict_o.status  = '0;
    if (!verdict_o.exec_ok) begin
      if (key_deny)     verdict_o.status = verdict_o.status | STAT_KEY;
      if (!base_exec_i) verdict_o.status = verdict_o.status | STAT_BASE;
    end
  end
endmodule

// File: rtl/ifp_fetch_guard.sv
module ifp_fetch_guard
  import ifp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_wr_i,
  input  logic [DW-1:0]     mask_wdata_i,
  output logic [DW-1:0]     mask_rdata_o,
  input  logic              req_valid_i,
  input  logic [DW-1:0]     pte_dw1_i,
  input  logic              base_exec_i,
  input  logic              key_chk_en_i,
  output logic              rsp_valid_o,
  output logic              exec_ok_o,
  output logic [STAT_W-1:0] status_o
);
  key_t     key;
  fld_t     fld;
  verdict_t verdict_d, verdict_q;
  logic     vld_q;

  ifp_key_extract u_key (
    .pte_dw1_i (pte_dw1_i),
    .key_o     (key)
  );

  ifp_mask_reg u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (mask_wr_i),
    .wdata_i (mask_wdata_i),
    .key_i   (key),
    .q_o     (mask_rdata_o),
    .fld_o   (fld)
  );

  ifp_decide u_dec (
    .base_exec_i  (base_exec_i),
    .key_chk_en_i (key_chk_en_i),
    .fld_i        (fld),
    .verdict_o    (verdict_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q     <= 1'b0;
      verdict_q <= '0;
    end else begin
      vld_q <= req_valid_i;
      if (req_valid_i) verdict_q <= verdict_d;
    end
  end

  assign rsp_valid_o = vld_q;
  assign exec_ok_o   = verdict_q.exec_ok;
  assign status_o    = verdict_q.status;
endmodule

// File: rtl/ifp_fetch_guard_chk.sv
module ifp_fetch_guard_chk
  import ifp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mask_wr_i,
  input logic [DW-1:0]     mask_wdata_i,
  input logic [DW-1:0]     mask_rdata_o,
  input logic              req_valid_i,
  input logic              base_exec_i,
  input logic              key_chk_en_i,
  input logic              rsp_valid_o,
  input logic              exec_ok_o,
  input logic [STAT_W-1:0] status_o
);
  p_rsp_follows_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_no_spurious_rsp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  p_allow_status_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && exec_ok_o) |-> (status_o == '0));

  p_deny_has_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !exec_ok_o) |-> ((status_o & (STAT_KEY | STAT_BASE)) != '0));

  p_base_deny_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !base_exec_i) |=> (!exec_ok_o && status_o[27]));

  p_key_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !key_chk_en_i) |=> (exec_ok_o == $past(base_exec_i) && !status_o[21]));

  p_mask_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr_i |=> (mask_rdata_o == $past(mask_wdata_i)));

  p_mask_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_wr_i |=> $stable(mask_rdata_o));
endmodule

bind ifp_fetch_guard ifp_fetch_guard_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mask_wr_i    (mask_wr_i),
  .mask_wdata_i (mask_wdata_i),
  .mask_rdata_o (mask_rdata_o),
  .req_valid_i  (req_valid_i),
  .base_exec_i  (base_exec_i),
  .key_chk_en_i (key_chk_en_i),
  .rsp_valid_o  (rsp_valid_o),
  .exec_ok_o    (exec_ok_o),
  .status_o     (status_o)
);

// File: tb/ifp_fetch_guard_tb.sv
module ifp_fetch_guard_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mask_wr_i = 1'b0;
  logic [63:0] mask_wdata_i = '0;
  logic [63:0] mask_rdata_o;
  logic        req_valid_i = 1'b0;
  logic [63:0] pte_dw1_i = '0;
  logic        base_exec_i = 1'b0;
  logic        key_chk_en_i = 1'b0;
  logic        rsp_valid_o;
  logic        exec_ok_o;
  logic [31:0] status_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] mdl_mask = '0;

  typedef struct {
    logic        ok;
    logic [31:0] st;
    string       tag;
  } exp_t;
  exp_t sb [$];

  always #10 clk_i = ~clk_i;

  ifp_fetch_guard u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .mask_rdata_o (mask_rdata_o),
    .req_valid_i  (req_valid_i),
    .pte_dw1_i    (pte_dw1_i),
    .base_exec_i  (base_exec_i),
    .key_chk_en_i (key_chk_en_i),
    .rsp_valid_o  (rsp_valid_o),
    .exec_ok_o    (exec_ok_o),
    .status_o     (status_o)
  );

  function automatic logic [63:0] mk_pte(input logic [4:0] k, input logic [63:0] noise);
    logic [63:0] p;
    p = noise;
    p[61:60] = k[4:3];
    p[11:9]  = k[2:0];
    return p;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle starting at a falling edge
  task automatic cyc(input logic wr, input logic [63:0] wd, input logic req,
                     input logic [63:0] pte, input logic base, input logic en, input string tag);
    logic [4:0] k;
    logic       kd;
    exp_t       e;
    mask_wr_i = wr; mask_wdata_i = wd;
    req_valid_i = req; pte_dw1_i = pte; base_exec_i = base; key_chk_en_i = en;
    if (req) begin
      k    = {pte[61:60], pte[11:9]};
      kd   = en & mdl_mask[2*(31-k)];
      e.ok = base & ~kd;
      e.st = '0;
      if (kd)    e.st[21] = 1'b1;
      if (!base) e.st[27] = 1'b1;
      e.tag = tag;
      sb.push_back(e);
    end
    @(negedge clk_i);
    if (wr) mdl_mask = wd;
    mask_wr_i = 1'b0; req_valid_i = 1'b0;
  endtask

  task automatic req(input logic [63:0] pte, input logic base, input logic en, input string tag);
    cyc(1'b0, '0, 1'b1, pte, base, en, tag);
  endtask

  task automatic wr(input logic [63:0] wd);
    cyc(1'b1, wd, 1'b0, '0, 1'b0, 1'b0, "");
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (rsp_valid_o) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9: actual unexpected response expected none");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " exec_ok"}, {63'd0, exec_ok_o}, {63'd0, e.ok});
          check({e.tag, " status"}, {32'd0, status_o}, {32'd0, e.st});
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset mask", mask_rdata_o, '0);
    check("R1 reset valid", {63'd0, rsp_valid_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 mask after reset", mask_rdata_o, '0);

    req(mk_pte(5'd17, 64'h0), 1'b1, 1'b1, "R1 all keys allowed");
    @(negedge clk_i);

    // key 0x0A: field bits 43:42 = 01
    wr(64'h0000_0400_0000_0000);
    check("R10 readback", mask_rdata_o, 64'h0000_0400_0000_0000);
    req(mk_pte(5'h0A, 64'h0), 1'b1, 1'b1, "R6 R3 key 0x0A denied");
    req(mk_pte(5'h0A, 64'h0), 1'b1, 1'b0, "R5 disabled key check");
    req(mk_pte(5'h0A, 64'h0), 1'b0, 1'b1, "R7 both causes");
    req(mk_pte(5'h0A, 64'h0), 1'b0, 1'b0, "R7 base only");
    req(mk_pte(5'h0B, 64'h0), 1'b1, 1'b1, "R2 neighbour key allowed");
    @(negedge clk_i);

    // upper field bit only, key 5 -> bit 53
    wr(64'h0020_0000_0000_0000);
    req(mk_pte(5'd5, 64'h0), 1'b1, 1'b1, "R4 upper bit ignored");
    @(negedge clk_i);

    // key 0 (bit 62) and key 31 (bit 0)
    wr(64'h4000_0000_0000_0001);
    req(mk_pte(5'd0, 64'h0), 1'b1, 1'b1, "R3 key 0 denied");
    req(mk_pte(5'd31, 64'h0), 1'b1, 1'b1, "R3 key 31 denied");
    req(mk_pte(5'd1, 64'h0), 1'b1, 1'b1, "R3 key 1 allowed");
    req(mk_pte(5'd30, 64'h0), 1'b1, 1'b1, "R3 key 30 allowed");
    req(mk_pte(5'd0, ~64'h0), 1'b1, 1'b1, "R2 noisy pte key 0");
    req(mk_pte(5'd1, ~64'h0), 1'b1, 1'b1, "R2 noisy pte key 1");
    @(negedge clk_i);

    // write and request in the same cycle: old mask applies
    cyc(1'b1, 64'h0000_0000_0000_0004, 1'b1, mk_pte(5'd30, 64'h0), 1'b1, 1'b1, "R10 same-cycle old mask");
    req(mk_pte(5'd30, 64'h0), 1'b1, 1'b1, "R10 new mask next cycle");
    req(mk_pte(5'd0, 64'h0), 1'b1, 1'b1, "R10 key 0 now allowed");
    check("R10 readback second", mask_rdata_o, 64'h0000_0000_0000_0004);

    for (int i = 0; i < 32; i++) begin
      req(mk_pte(5'(i), 64'h5A5A_0000_0000_0000), 1'(i[0]), 1'b1, "R9 back-to-back sweep");
    end
    repeat (3) @(negedge clk_i);
    check("R9 scoreboard drained", 64'(sb.size()), '0);
    check("R9 valid low when idle", {63'd0, rsp_valid_o}, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule